// File: doc/BRIEF.md
# Shared Address/Data Register Port

This block is the slave side of a small processor-style register port in which one 8-bit line set carries both the register address and the data. The host first drives an address on the shared lines and pulses a latch-enable strobe. It then drives an active-low read or write strobe while an active-low select is asserted. None of the control pins is tied to the block's clock. The block brings all of them, together with the shared lines, through a multi-stage synchronizer. Every action is then decided from edges of the synchronized strobes.

Behind the port sit two registers. The first is a control register that the host can read and write. Its bits also act as per-source enables for event reporting. The second is an event status register that the host can only read. Each bit latches an enabled event pulse from the surrounding logic and clears once the host has read it. There is no tri-state pad inside the block. Read data and a drive-enable come out as separate outputs for the pad ring.

Top module: `mux_regbus_slave`

## Requirements
- R1: After reset the control output is 0x00, the status register is 0x00 and the drive-enable `ad_oe_o` is low.
- R2: The register address is the value on `ad_i` during the last sampled cycle in which `ale_i` was high. It is kept after `ale_i` falls and is used by the accesses that follow.
- R3: A write (`wr_n_i` low, `cs_n_i` low, `rd_n_i` high) takes the value on `ad_i` during its last sampled active cycle. That value is committed when either `wr_n_i` or `cs_n_i` returns high. The control register sits at address 0x00, and `ctrl_o` changes SYNC_STAGES+1 clocks after the ending pin edge.
- R4: While `rd_n_i` and `cs_n_i` are low and `wr_n_i` is high, `ad_oe_o` is high and `ad_out_o` holds the addressed register's value taken at the start of the read. `ad_oe_o` rises and falls SYNC_STAGES+1 clocks after the pins change.
- R5: The status register is at address 0x01. On each clock, every bit that is set in both `irq_event_i` and the control register becomes set in the status register.
- R6: A read of the status register clears the bits it returned when the read ends. A bit whose event is present in the clearing cycle stays set.
- R7: Writes to any address other than 0x00 and 0x01 change nothing. Reads of such an address return 0x00.
- R8: A write to the status address does not change the status register.
- R9: With `cs_n_i` high, read and write strobes have no effect: `ad_oe_o` stays low and `ctrl_o` is unchanged.
- R10: If read and write strobes are both low at once, neither a read nor a write takes place.
- R11: `cs_n_i` may be held low permanently, and writes and reads still work through the read and write strobes alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, at least 4x faster than the host strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch strobe, active high, asynchronous |
| cs_n_i | input | 1 | Select, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| ad_i | input | DW | Shared address/data lines, input side |
| ad_out_o | output | DW | Read data for the shared lines |
| ad_oe_o | output | 1 | Drive-enable for the shared lines |
| irq_event_i | input | DW | Per-bit event pulses, synchronous to clk |
| ctrl_o | output | DW | Current control register value |

## Verification
The bench aims at the read that clears status while the same event is still firing. A design that lets the clear win would lose an event that the host never saw. Writes ended by the select rather than the write strobe are tested because a design that watches only `wr_n_i` would miss the commit. Selectless strobes and overlapping read/write strobes are driven, where a loose decoder would drive the lines or corrupt the control register. Reads and writes of unmapped and read-only addresses check that nothing aliases onto the two real registers.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
   // Decoded bus actions, one clock wide except rd_active
   typedef struct packed {
      logic rd_active;
      logic rd_start;
      logic rd_end;
      logic wr_commit;
   } bus_act_t;
endpackage

// File: rtl/mrb_sync.sv
module mrb_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         initial $error("mrb_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else             stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mrb_decode.sv
module mrb_decode
   import mrb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale_s,
   input  logic          cs_s,
   input  logic          rd_s,
   input  logic          wr_s,
   input  logic [DW-1:0] ad_s,
   output logic [DW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output bus_act_t      act_o
);
   logic rd_now, wr_now, rd_was, wr_was;

   // A strobe counts only with select and without the opposite strobe
   assign rd_now = rd_s & cs_s & ~wr_s;
   assign wr_now = wr_s & cs_s & ~rd_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_was  <= 1'b0;
         wr_was  <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
      end else begin
         rd_was <= rd_now;
         wr_was <= wr_now;
         if (ale_s)  addr_o  <= ad_s;   // last value before the strobe falls stays
         if (wr_now) wdata_o <= ad_s;   // last value before the write ends stays
      end
   end

   assign act_o.rd_active = rd_now;
   assign act_o.rd_start  = rd_now & ~rd_was;
   assign act_o.rd_end    = rd_was & ~rd_now;
   assign act_o.wr_commit = wr_was & ~wr_now;
endmodule

// File: rtl/mrb_regfile.sv
module mrb_regfile
   import mrb_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [DW-1:0] CTRL_ADDR = 8'h00,
   parameter logic [DW-1:0] STAT_ADDR = 8'h01,
   parameter logic [DW-1:0] CTRL_RST  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  bus_act_t      act_i,
   input  logic [DW-1:0] event_i,
   output logic [DW-1:0] ctrl_o,
   output logic [DW-1:0] status_o,
   output logic [DW-1:0] rdata_o,
   output logic          oe_o
);
   logic [DW-1:0] ctrl_q, stat_q, clr_q, rdata_q, read_mux;
   logic          oe_q;

   always_comb begin
      if (addr_i == CTRL_ADDR)      read_mux = ctrl_q;
      else if (addr_i == STAT_ADDR) read_mux = stat_q;
      else                          read_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         stat_q  <= '0;
         clr_q   <= '0;
         rdata_q <= '0;
         oe_q    <= 1'b0;
      end else begin
         oe_q <= act_i.rd_active;
         if (act_i.wr_commit && addr_i == CTRL_ADDR) ctrl_q <= wdata_i;
         if (act_i.rd_start) begin
            rdata_q <= read_mux;
            clr_q   <= (addr_i == STAT_ADDR) ? stat_q : '0;
         end
         // new events outrank the clear
         stat_q <= (stat_q & ~(act_i.rd_end ? clr_q : '0)) | (event_i & ctrl_q);
      end
   end

   assign ctrl_o   = ctrl_q;
   assign status_o = stat_q;
   assign rdata_o  = rdata_q;
   assign oe_o     = oe_q;
endmodule

// File: rtl/mux_regbus_slave.sv
module mux_regbus_slave
   import mrb_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [DW-1:0] CTRL_ADDR   = 8'h00,
   parameter logic [DW-1:0] STAT_ADDR   = 8'h01,
   parameter logic [DW-1:0] CTRL_RST    = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale_i,
   input  logic          cs_n_i,
   input  logic          rd_n_i,
   input  logic          wr_n_i,
   input  logic [DW-1:0] ad_i,
   output logic [DW-1:0] ad_out_o,
   output logic          ad_oe_o,
   input  logic [DW-1:0] irq_event_i,
   output logic [DW-1:0] ctrl_o
);
   localparam int SW = DW + 4;
   localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {DW{1'b0}}};

   generate
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_map
         initial $error("mux_regbus_slave: register addresses collide");
      end
   endgenerate

   logic [SW-1:0] pins_w, pins_s;
   logic [DW-1:0] addr_w, wdata_w, status_w;
   bus_act_t      act_w;

   assign pins_w = {ale_i, cs_n_i, rd_n_i, wr_n_i, ad_i};

   mrb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_w), .q_o(pins_s)
   );

   mrb_decode #(.DW(DW)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .ale_s(pins_s[DW+3]), .cs_s(~pins_s[DW+2]),
      .rd_s(~pins_s[DW+1]), .wr_s(~pins_s[DW]),
      .ad_s(pins_s[DW-1:0]),
      .addr_o(addr_w), .wdata_o(wdata_w), .act_o(act_w)
   );

   mrb_regfile #(.DW(DW), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
                 .CTRL_RST(CTRL_RST)) u_rf (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_w), .wdata_i(wdata_w),
      .act_i(act_w), .event_i(irq_event_i), .ctrl_o(ctrl_o),
      .status_o(status_w), .rdata_o(ad_out_o), .oe_o(ad_oe_o)
   );
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker #(
   parameter int          DW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [DW-1:0] CTRL_ADDR   = 8'h00,
   parameter logic [DW-1:0] STAT_ADDR   = 8'h01
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n_i,
   input logic          rd_n_i,
   input logic          wr_n_i,
   input logic          ad_oe_o,
   input logic [DW-1:0] ad_out_o,
   input logic [DW-1:0] irq_event_i,
   input logic [DW-1:0] ctrl_o,
   input logic [DW-1:0] status,
   input logic [DW-1:0] addr
);
   localparam int LAT = SYNC_STAGES + 1;

   // R4, R9, R10: drive only after a clean selected read reached the core
   a_r4_oe_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe_o |-> ($past(rd_n_i, LAT) == 1'b0 && $past(cs_n_i, LAT) == 1'b0
                   && $past(wr_n_i, LAT) == 1'b1));

   // R3: control changes only after a write or select pin went high
   a_r3_ctrl_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> ($past(wr_n_i, LAT) || $past(cs_n_i, LAT)));

   // R5, R6: an enabled event always lands in status, clear or not
   a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_event_i & ctrl_o)) |=>
         ((status & $past(irq_event_i & ctrl_o)) == $past(irq_event_i & ctrl_o)));

   // R7: unmapped reads return zero
   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe_o && addr != CTRL_ADDR && addr != STAT_ADDR) |-> ad_out_o == '0);
endmodule

bind mux_regbus_slave mrb_checker #(
   .DW(DW), .SYNC_STAGES(SYNC_STAGES), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
   .ad_oe_o(ad_oe_o), .ad_out_o(ad_out_o), .irq_event_i(irq_event_i),
   .ctrl_o(ctrl_o), .status(status_w), .addr(addr_w)
);

// File: tb/mux_regbus_slave_bench.sv
`timescale 1ns/1ps
module mux_regbus_slave_bench;
   logic       clk = 0, rst_n = 0;
   logic       ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
   logic [7:0] ad = 0, evt = 0;
   logic [7:0] ad_out, ctrl;
   logic       oe;
   int         n_chk = 0, n_fail = 0;
   bit         cs_hold = 0;
   bit         oe_seen;

   always #5 clk = ~clk;

   mux_regbus_slave u_mux_regbus_slave (
      .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
      .wr_n_i(wr_n), .ad_i(ad), .ad_out_o(ad_out), .ad_oe_o(oe),
      .irq_event_i(evt), .ctrl_o(ctrl)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [11:0] pin_q[$];        // pin samples waiting to reach the core
   logic [7:0]  m_addr, m_wdata, m_ctrl, m_stat, m_clr, m_rdata;
   bit          m_oe, m_prd, m_pwr;

   function automatic logic [7:0] m_read(input logic [7:0] a);
      if (a == 8'h00) return m_ctrl;
      if (a == 8'h01) return m_stat;
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_q = {12'h700, 12'h700};
         m_addr = 0; m_wdata = 0; m_ctrl = 0; m_stat = 0; m_clr = 0; m_rdata = 0;
         m_oe = 0; m_prd = 0; m_pwr = 0;
      end else begin
         logic [11:0] s;
         bit rd, wr, ra, wa;
         logic [7:0] nstat;
         s  = pin_q.pop_front();
         rd = !s[9]; wr = !s[8];
         ra = rd && !s[10] && !wr;
         wa = wr && !s[10] && !rd;
         nstat = m_stat;
         if (m_prd && !ra) nstat &= ~m_clr;
         nstat |= evt & m_ctrl;
         if (ra && !m_prd) begin
            m_rdata = m_read(m_addr);
            m_clr   = (m_addr == 8'h01) ? m_stat : 8'h00;
         end
         if (m_pwr && !wa && m_addr == 8'h00) m_ctrl = m_wdata;
         if (s[11]) m_addr  = s[7:0];
         if (wa)    m_wdata = s[7:0];
         m_stat = nstat; m_oe = ra; m_prd = ra; m_pwr = wa;
         pin_q.push_back({ale, cs_n, rd_n, wr_n, ad});
      end
   end

   always @(negedge clk) if (rst_n) begin
      chk("R4 oe model", {7'b0, oe}, {7'b0, m_oe});
      chk("R3 ctrl model", ctrl, m_ctrl);
      if (m_oe) chk("R4 data model", ad_out, m_rdata);
      if (oe) oe_seen = 1;
   end

   // ---------------- bus tasks ----------------
   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic addr_phase(input logic [7:0] a);
      ad = a; ale = 1; clks(4);
      ale = 0; clks(2);
   endtask

   task automatic wr_access(input logic [7:0] a, input logic [7:0] d,
                            input bit end_by_cs, input bit use_cs);
      addr_phase(a);
      ad = d;
      if (use_cs) cs_n = 0;
      wr_n = 0; clks(5);
      if (end_by_cs) cs_n = 1; else wr_n = 1;
      clks(2);
      wr_n = 1; if (!cs_hold) cs_n = 1;
      clks(5);
   endtask

   task automatic rd_access(input logic [7:0] a, input bit use_cs, output logic [7:0] d);
      addr_phase(a);
      d = 8'hxx;
      if (use_cs) cs_n = 0;
      rd_n = 0;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         if (oe) d = ad_out;
      end
      rd_n = 1; if (!cs_hold) cs_n = 1;
      clks(5);
   endtask

   initial begin
      int wd = 0;
      while (wd < 100000) begin @(posedge clk); wd++; end
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] r;
      clks(3); rst_n = 1; clks(2);
      chk("R1 ctrl reset", ctrl, 8'h00);
      chk("R1 oe reset", {7'b0, oe}, 8'h00);
      rd_access(8'h01, 1, r); chk("R1 status reset", r, 8'h00);

      wr_access(8'h00, 8'h0F, 0, 1); chk("R3 write ctrl", ctrl, 8'h0F);
      rd_access(8'h00, 1, r);        chk("R2 R4 read ctrl", r, 8'h0F);

      evt = 8'h35; clks(1); evt = 0; clks(1);
      rd_access(8'h01, 1, r); chk("R5 enabled events only", r, 8'h05);
      rd_access(8'h01, 1, r); chk("R6 cleared after read", r, 8'h00);

      evt = 8'h02;
      rd_access(8'h01, 1, r); chk("R6 read with live event", r, 8'h02);
      evt = 0;
      rd_access(8'h01, 1, r); chk("R6 event at clear kept", r, 8'h02);
      rd_access(8'h01, 1, r); chk("R6 then cleared", r, 8'h00);

      wr_access(8'h01, 8'hFF, 0, 1);
      rd_access(8'h01, 1, r); chk("R8 status write ignored", r, 8'h00);

      wr_access(8'h7E, 8'hAA, 0, 1); chk("R7 unmapped write", ctrl, 8'h0F);
      rd_access(8'h7E, 1, r);        chk("R7 unmapped read", r, 8'h00);

      wr_access(8'h00, 8'h55, 0, 0); chk("R9 write without select", ctrl, 8'h0F);
      oe_seen = 0;
      rd_access(8'h00, 0, r);
      chk("R9 no drive without select", {7'b0, oe_seen}, 8'h00);

      wr_access(8'h00, 8'h3C, 1, 1); chk("R3 commit on select end", ctrl, 8'h3C);

      addr_phase(8'h00); oe_seen = 0;
      ad = 8'h99; cs_n = 0; rd_n = 0; wr_n = 0; clks(6);
      rd_n = 1; wr_n = 1; cs_n = 1; clks(5);
      chk("R10 overlap no write", ctrl, 8'h3C);
      chk("R10 overlap no drive", {7'b0, oe_seen}, 8'h00);

      cs_hold = 1; cs_n = 0; clks(2);
      wr_access(8'h00, 8'h81, 0, 1); chk("R11 select held write", ctrl, 8'h81);
      rd_access(8'h00, 1, r);        chk("R11 select held read", r, 8'h81);
      cs_hold = 0; cs_n = 1; clks(4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule